// File: doc/BRIEF.md
# Timer Register Access Controller

This block is the byte-wide register front end of a three-channel programmable interval timer. A host reaches it through a 2-bit address, a write strobe, a read strobe and 8-bit data. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. The block decodes control words and keeps, for each channel, the byte ordering used on its data port. It also holds a latched count and a latched status byte per channel, and it carries out the multi-channel read-back command.

The counting engines sit outside this block. Toward each channel the block sends a one-cycle load pulse with a 16-bit start value, and a one-cycle configuration pulse with the counting mode and the BCD flag. From each channel it receives the live 16-bit count and the output level.

The host bus takes one access per clock and has no back-pressure. A write completes in the cycle its strobe is sampled. Read data is registered: `rd_valid` is high for one cycle, in the cycle after the read strobe, and qualifies `rdata` in that cycle. If the write and read strobes are both high in the same cycle, the write is performed and the read is dropped.

Top module: `tmr_regif`

## Requirements
- R1: Address 0 to 2 selects the data port of the channel with that number, and address 3 selects the control port. A read of the control port returns 8'hFF. Read data appears one cycle after `rd_en`, qualified by `rd_valid`. A read issued in the same cycle as a write is dropped, so `rd_valid` stays low.
- R2: A control word is decoded as follows. Bits 7:6 select the channel, and 3 in that field means read-back. Bits 5:4 give the access mode: 1 = low byte only, 2 = high byte only, 3 = low then high, 0 = count latch. Bits 3:1 give the counting mode and bit 0 the BCD flag. A word that is not a latch command updates `ch_mode`/`ch_bcd` of the selected channel and pulses its `ch_cfg` bit for one cycle.
- R3: In low-only mode a data write loads {8'h00, byte}. In high-only mode it loads {byte, 8'h00}. The load pulse and the value appear on `ch_load`/`ch_load_val` in the cycle after the write.
- R4: In low-then-high mode the first data write only holds its byte and does not load. The second write loads {second, first}. Any non-latch control word for a channel restarts both of its byte sequencers at the low byte.
- R5: A read without a pending latch returns the live count. Low-only mode returns count[7:0]. High-only mode returns count[15:8]. Low-then-high mode alternates low, high, low... starting from the low byte.
- R6: A count latch command captures the live count of the channel in the cycle the command is written. Later reads return the captured value even while the count moves. In low-then-high mode the latch gives the low byte, then the high byte, and is then released. In the single-byte modes one read releases it.
- R7: A read-back command (bits 7:6 = 3) affects every channel whose select bit is set: bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2. Bit 5 = 0 requests a count latch and bit 4 = 0 requests a status latch. Channels that are not selected are not affected.
- R8: The status byte holds the output level in bit 7, 0 in bit 6, the access mode in bits 5:4, the counting mode in bits 3:1 and the BCD flag in bit 0. It is captured when the command is written.
- R9: A data read returns a pending status first and clears only that status. If no status is pending, it returns a pending count latch. Otherwise it returns the live count. A latched read does not advance the live-read byte order.
- R10: A count latch request is ignored while an earlier count latch of the same channel has not been fully read. A status latch request is likewise ignored while an earlier status is still unread.
- R11: After reset every channel is in low-then-high access, mode 0, BCD 0. No latch is pending, both sequencers are at the low byte, and `rd_valid`, `ch_load` and `ch_cfg` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port select: 0..2 channel data, 3 control |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after an accepted read |
| ch_load | output | 3 | Per-channel count load pulse |
| ch_load_val | output | 48 | Per-channel 16-bit load value, channel n at [16n+15:16n] |
| ch_cfg | output | 3 | Per-channel configuration pulse |
| ch_mode | output | 9 | Per-channel counting mode, channel n at [3n+2:3n] |
| ch_bcd | output | 3 | Per-channel BCD flag |
| ch_count | input | 48 | Per-channel live count, channel n at [16n+15:16n] |
| ch_out | input | 3 | Per-channel output level |

## Verification
The hardest situation to reach from the ports is a latch that must ignore a second request while the counter underneath keeps moving. The freeze is only visible when the live value and the held value differ. The bench runs a simple decrementing counter model on channel 2 and notes the model value in the cycle the latch command is written. It issues a second latch some cycles later and then checks that both bytes still match the first capture. Status is handled the same way: the output level is changed between two read-back commands, and the bench confirms that the first status byte survives and that the following read goes back to the live count.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

  // Access mode field of a control word
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  localparam logic [1:0] CTRL_PORT    = 2'd3;
  localparam logic [1:0] SEL_READBACK = 2'd3;

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_regif_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [NCH-1:0] ctl_wr,
  output logic [NCH-1:0] cnt_req,
  output logic [NCH-1:0] sts_req,
  output logic [NCH-1:0] dat_wr,
  output logic [NCH-1:0] dat_rd,
  output logic          rd_go
);

  logic [1:0] sel;
  logic [1:0] acc;

  assign sel   = wdata[7:6];
  assign acc   = wdata[5:4];
  assign rd_go = rd_en && !wr_en;

  always_comb begin
    ctl_wr  = '0;
    cnt_req = '0;
    sts_req = '0;
    dat_wr  = '0;
    dat_rd  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (wr_en && addr == CTRL_PORT) begin
        if (sel == SEL_READBACK) begin
          if (wdata[i+1]) begin
            cnt_req[i] = !wdata[5];
            sts_req[i] = !wdata[4];
          end
        end else if (sel == 2'(i)) begin
          if (acc == ACC_LATCH) cnt_req[i] = 1'b1;
          else                  ctl_wr[i]  = 1'b1;
        end
      end
      if (wr_en && addr == 2'(i)) dat_wr[i] = 1'b1;
      if (rd_go && addr == 2'(i)) dat_rd[i] = 1'b1;
    end
  end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_regif_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          cnt_req,
  input  logic          sts_req,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  input  logic [2*DW-1:0] live_cnt,
  input  logic          out_lvl,
  output logic [DW-1:0] rd_byte,
  output logic          load_o,
  output logic [2*DW-1:0] load_val_o,
  output logic          cfg_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o
);

  localparam int CW = 2 * DW;

  acc_e          acc_q;
  logic [2:0]    mode_q;
  logic          bcd_q;
  logic          wr_hi_q;
  logic          rd_hi_q;
  logic [DW-1:0] hold_q;
  logic          lat_vld_q;
  acc_e          lat_acc_q;
  logic          lat_hi_q;
  logic [CW-1:0] lat_q;
  logic          sts_vld_q;
  logic [DW-1:0] sts_q;
  logic          load_q;
  logic [CW-1:0] load_val_q;
  logic          cfg_q;

  assign load_o     = load_q;
  assign load_val_o = load_val_q;
  assign cfg_o      = cfg_q;
  assign mode_o     = mode_q;
  assign bcd_o      = bcd_q;

  // Read source priority: status, then count latch, then live count
  always_comb begin
    if (sts_vld_q) begin
      rd_byte = sts_q;
    end else if (lat_vld_q) begin
      unique case (lat_acc_q)
        ACC_HI:   rd_byte = lat_q[CW-1:DW];
        ACC_WORD: rd_byte = lat_hi_q ? lat_q[CW-1:DW] : lat_q[DW-1:0];
        default:  rd_byte = lat_q[DW-1:0];
      endcase
    end else begin
      unique case (acc_q)
        ACC_HI:   rd_byte = live_cnt[CW-1:DW];
        ACC_WORD: rd_byte = rd_hi_q ? live_cnt[CW-1:DW] : live_cnt[DW-1:0];
        default:  rd_byte = live_cnt[DW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_q     <= '0;
      lat_vld_q  <= 1'b0;
      lat_acc_q  <= ACC_WORD;
      lat_hi_q   <= 1'b0;
      lat_q      <= '0;
      sts_vld_q  <= 1'b0;
      sts_q      <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
      cfg_q      <= 1'b0;
    end else begin
      load_q <= 1'b0;
      cfg_q  <= 1'b0;

      if (ctl_wr) begin
        acc_q   <= acc_e'(wdata[5:4]);
        mode_q  <= wdata[3:1];
        bcd_q   <= wdata[0];
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
        cfg_q   <= 1'b1;
      end

      if (cnt_req && !lat_vld_q) begin
        lat_vld_q <= 1'b1;
        lat_q     <= live_cnt;
        lat_acc_q <= acc_q;
        lat_hi_q  <= 1'b0;
      end

      if (sts_req && !sts_vld_q) begin
        sts_vld_q <= 1'b1;
        sts_q     <= {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
      end

      if (dat_wr) begin
        unique case (acc_q)
          ACC_HI: begin
            load_q     <= 1'b1;
            load_val_q <= {wdata, {DW{1'b0}}};
          end
          ACC_WORD: begin
            if (!wr_hi_q) begin
              hold_q  <= wdata;
              wr_hi_q <= 1'b1;
            end else begin
              load_q     <= 1'b1;
              load_val_q <= {wdata, hold_q};
              wr_hi_q    <= 1'b0;
            end
          end
          default: begin
            load_q     <= 1'b1;
            load_val_q <= {{DW{1'b0}}, wdata};
          end
        endcase
      end

      if (dat_rd) begin
        if (sts_vld_q) begin
          sts_vld_q <= 1'b0;
        end else if (lat_vld_q) begin
          if (lat_acc_q == ACC_WORD && !lat_hi_q) lat_hi_q  <= 1'b1;
          else                                    lat_vld_q <= 1'b0;
        end else if (acc_q == ACC_WORD) begin
          rd_hi_q <= !rd_hi_q;
        end
      end
    end
  end

  // R4
  word_first_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && acc_q == ACC_WORD && !wr_hi_q |=> !load_q);

  // R4
  ctl_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !wr_hi_q && !rd_hi_q);

  // R3
  load_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> $past(dat_wr));

  // R10
  cnt_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_vld_q && cnt_req |=> lat_q == $past(lat_q));

  // R10
  sts_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_vld_q && sts_req |=> sts_q == $past(sts_q));

  // R9
  sts_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd && sts_vld_q |=> !sts_vld_q && lat_vld_q == $past(lat_vld_q)
                            && rd_hi_q == $past(rd_hi_q));

endmodule

// File: rtl/tmr_rd_port.sv
module tmr_rd_port #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      addr,
  input  logic            rd_go,
  input  logic [NCH*DW-1:0] ch_bytes,
  output logic [DW-1:0]   rdata,
  output logic            rd_valid
);

  logic [DW-1:0] sel_byte;

  always_comb begin
    sel_byte = '1;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) sel_byte = ch_bytes[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rdata <= sel_byte;
    end
  end

  // R1
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_go));

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  input  logic              rd_en,
  output logic [DW-1:0]     rdata,
  output logic              rd_valid,
  output logic [NCH-1:0]    ch_load,
  output logic [NCH*2*DW-1:0] ch_load_val,
  output logic [NCH-1:0]    ch_cfg,
  output logic [NCH*3-1:0]  ch_mode,
  output logic [NCH-1:0]    ch_bcd,
  input  logic [NCH*2*DW-1:0] ch_count,
  input  logic [NCH-1:0]    ch_out
);

  localparam int CW = 2 * DW;

  logic [NCH-1:0]    ctl_wr;
  logic [NCH-1:0]    cnt_req;
  logic [NCH-1:0]    sts_req;
  logic [NCH-1:0]    dat_wr;
  logic [NCH-1:0]    dat_rd;
  logic              rd_go;
  logic [NCH*DW-1:0] ch_bytes;

  tmr_cmd_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .ctl_wr  (ctl_wr),
    .cnt_req (cnt_req),
    .sts_req (sts_req),
    .dat_wr  (dat_wr),
    .dat_rd  (dat_rd),
    .rd_go   (rd_go)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan_port #(.DW(DW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr[g]),
      .cnt_req    (cnt_req[g]),
      .sts_req    (sts_req[g]),
      .dat_wr     (dat_wr[g]),
      .dat_rd     (dat_rd[g]),
      .wdata      (wdata),
      .live_cnt   (ch_count[g*CW +: CW]),
      .out_lvl    (ch_out[g]),
      .rd_byte    (ch_bytes[g*DW +: DW]),
      .load_o     (ch_load[g]),
      .load_val_o (ch_load_val[g*CW +: CW]),
      .cfg_o      (ch_cfg[g]),
      .mode_o     (ch_mode[g*3 +: 3]),
      .bcd_o      (ch_bcd[g])
    );
  end

  tmr_rd_port #(.NCH(NCH), .DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_go    (rd_go),
    .ch_bytes (ch_bytes),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  // R2
  one_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_cfg) && $onehot0(ch_load));

  // R1
  no_read_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en |=> !rd_valid);

endmodule

// File: tb/tmr_regif_test.sv
module tmr_regif_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        rd_valid;
  logic [2:0]  ch_load;
  logic [47:0] ch_load_val;
  logic [2:0]  ch_cfg;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [47:0] ch_count;
  logic [2:0]  ch_out = '0;

  logic [15:0] mdl [3];
  logic [2:0]  run = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Simple per-channel counter model
  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (!rst_n)          mdl[i] <= '0;
      else if (ch_load[i]) mdl[i] <= ch_load_val[i*16 +: 16];
      else if (run[i])     mdl[i] <= mdl[i] - 16'd1;
    end
  end
  assign ch_count = {mdl[2], mdl[1], mdl[0]};

  tmr_regif uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid), .ch_load(ch_load),
    .ch_load_val(ch_load_val), .ch_cfg(ch_cfg), .ch_mode(ch_mode),
    .ch_bcd(ch_bcd), .ch_count(ch_count), .ch_out(ch_out)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] b);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    b = rdata;
    n_chk++;
    if (rd_valid !== 1'b1) begin
      n_err++;
      $display("FAIL R1 rd_valid: actual %b expected 1", rd_valid);
    end
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk("R11 rd_valid at reset", 16'(rd_valid), 16'd0);
    chk("R11 ch_load at reset", 16'(ch_load), 16'd0);
    chk("R11 ch_mode at reset", 16'(ch_mode), 16'd0);
    chk("R11 ch_bcd at reset", 16'(ch_bcd), 16'd0);
    wr(2'd3, 8'hE2);                 // status only, channel 0
    rd(2'd0, b);
    chk("R11 reset status word access mode 0", 16'(b), 16'h0030);
    rd(2'd0, b);
    chk("R9 live after status", 16'(b), 16'h0000);
    rd(2'd3, b);
    chk("R1 control port read", 16'(b), 16'h00FF);
  endtask

  task automatic t_writes();
    wr(2'd3, 8'h14);                 // ch0 low only, mode 2
    chk("R2 cfg pulse", 16'(ch_cfg), 16'b001);
    chk("R2 mode ch0", 16'(ch_mode[2:0]), 16'd2);
    wr(2'd0, 8'h5A);
    chk("R3 low-only load pulse", 16'(ch_load), 16'b001);
    chk("R3 low-only value", ch_load_val[15:0], 16'h005A);
    @(negedge clk);
    chk("R3 load pulse one cycle", 16'(ch_load), 16'b000);
    wr(2'd3, 8'h24);                 // ch0 high only
    wr(2'd0, 8'h3C);
    chk("R3 high-only value", ch_load_val[15:0], 16'h3C00);
    wr(2'd3, 8'h34);                 // ch0 two byte
    wr(2'd0, 8'h11);
    chk("R4 first byte no load", 16'(ch_load), 16'b000);
    wr(2'd0, 8'h22);
    chk("R4 second byte load", 16'(ch_load), 16'b001);
    chk("R4 combined value", ch_load_val[15:0], 16'h2211);
  endtask

  task automatic t_live_reads();
    logic [7:0] b;
    wr(2'd3, 8'h74);                 // ch1 two byte, mode 2
    chk("R2 mode ch1", 16'(ch_mode[5:3]), 16'd2);
    wr(2'd1, 8'h34);
    wr(2'd1, 8'h12);
    @(negedge clk);
    rd(2'd1, b); chk("R5 word read low", 16'(b), 16'h0034);
    rd(2'd1, b); chk("R5 word read high", 16'(b), 16'h0012);
    rd(2'd1, b); chk("R5 word read low again", 16'(b), 16'h0034);
    wr(2'd3, 8'h54);                 // low only
    rd(2'd1, b); chk("R5 low-only read", 16'(b), 16'h0034);
    rd(2'd1, b); chk("R5 low-only repeat", 16'(b), 16'h0034);
    wr(2'd3, 8'h64);                 // high only
    rd(2'd1, b); chk("R5 high-only read", 16'(b), 16'h0012);
  endtask

  task automatic t_restart();
    logic [7:0] b;
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h99);                 // held, then abandoned
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h77);
    chk("R4 restart no load on first", 16'(ch_load), 16'b000);
    wr(2'd1, 8'h88);
    chk("R4 restart combined value", ch_load_val[31:16], 16'h8877);
    @(negedge clk);
    rd(2'd1, b); chk("R4 read low", 16'(b), 16'h0077);
    wr(2'd3, 8'h74);
    rd(2'd1, b); chk("R4 read order restarted", 16'(b), 16'h0077);
  endtask

  task automatic t_count_latch();
    logic [7:0]  b;
    logic [15:0] cap;
    wr(2'd3, 8'hB4);                 // ch2 two byte
    wr(2'd2, 8'hCD);
    wr(2'd2, 8'hAB);
    run[2] = 1'b1;
    repeat (5) @(negedge clk);
    cap = mdl[2];
    wr(2'd3, 8'h80);                 // latch ch2
    repeat (7) @(negedge clk);
    wr(2'd3, 8'h80);                 // ignored, first latch unread
    repeat (3) @(negedge clk);
    rd(2'd2, b); chk("R6 latched low", 16'(b), 16'(cap[7:0]));
    rd(2'd2, b); chk("R10 latched high after ignored relatch", 16'(b), 16'(cap[15:8]));
    run[2] = 1'b0;
    @(negedge clk);
    rd(2'd2, b); chk("R6 live after release", 16'(b), 16'(mdl[2][7:0]));
    rd(2'd2, b); chk("R9 live high next", 16'(b), 16'(mdl[2][15:8]));
    wr(2'd3, 8'h94);                 // ch2 low only
    cap = mdl[2];
    wr(2'd3, 8'h80);
    rd(2'd2, b); chk("R6 single-byte latch", 16'(b), 16'(cap[7:0]));
  endtask

  task automatic t_readback();
    logic [7:0] b;
    wr(2'd3, 8'h36);                 // ch0 two byte, mode 3
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    ch_out[0] = 1'b1;
    @(negedge clk);
    wr(2'd3, 8'hC2);                 // count + status, ch0
    rd(2'd0, b); chk("R8 status byte", 16'(b), 16'h00B6);
    rd(2'd0, b); chk("R9 count latch low after status", 16'(b), 16'h0000);
    rd(2'd0, b); chk("R7 count latch high", 16'(b), 16'h0001);
    wr(2'd3, 8'hE2);                 // status only
    ch_out[0] = 1'b0;
    @(negedge clk);
    wr(2'd3, 8'hE2);                 // ignored
    rd(2'd0, b); chk("R10 status kept first capture", 16'(b), 16'h00B6);
    rd(2'd0, b); chk("R10 no second status", 16'(b), 16'h0000);
    rd(2'd0, b); chk("R5 live high", 16'(b), 16'h0001);
    wr(2'd3, 8'h5B);                 // ch1 low only, mode 5, bcd
    wr(2'd3, 8'h9A);                 // ch2 low only, mode 5
    chk("R2 bcd ch1", 16'(ch_bcd), 16'b010);
    wr(2'd3, 8'hEC);                 // status ch1, ch2 only
    rd(2'd1, b); chk("R8 status ch1 bcd", 16'(b), 16'h001B);
    rd(2'd2, b); chk("R7 status ch2", 16'(b), 16'h001A);
    rd(2'd0, b); chk("R7 ch0 unselected live", 16'(b), 16'h0000);
  endtask

  task automatic t_collision();
    addr = 2'd3; wdata = 8'h7E; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R1 read dropped on write", 16'(rd_valid), 16'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_live_reads();
    t_restart();
    t_count_latch();
    t_readback();
    t_collision();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule